// File: doc/BRIEF.md
# Two-Wire Bus Slave with Broadcast Write Support

This block is a slave for the two-wire serial bus. It answers two kinds of address: its own 7-bit address, for writes and reads, and the all-zero broadcast address that every device on the bus shares. The bus clock and data lines enter through two-flop synchronizers. All START, STOP and clock-edge detection runs on the system clock. The block pulls the data line low through an open-drain enable and never drives it high.

Bytes written to the slave leave on a byte-wide strobe interface. A flag on that interface tells whether the byte came in through a broadcast. In a broadcast the first data byte is the command byte and sets the meaning of the whole transfer. The block latches it and presents it on a separate command output.

The block handles two commands itself: "reset and latch programmable address" and "latch programmable address only". It rejects a zero command. Every other command goes to user logic unchanged. For reads from its own address, the block requests each byte through a transmit-byte interface. A configuration input decides whether the block answers broadcasts at all.

Top module: `bcast_i2c_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and all strobe outputs (`rx_valid`, `gc_cmd_valid`, `soft_reset`, `addr_latch`, `tx_req`) are 0.
- R2: An address byte {own_addr, 0} is acknowledged. Each following data byte, shifted in MSB first on rising SCL, is acknowledged and given on `rx_data` with one `rx_valid` pulse and `rx_is_gc` = 0.
- R3: An address byte that matches neither `own_addr` nor the broadcast address is not acknowledged. No data from that transfer reaches the user side.
- R4: With `gc_enable` = 1, address byte 0x00 is acknowledged. The next byte is acknowledged and appears on `gc_cmd` with one `gc_cmd_valid` pulse. For a command other than 0x04 or 0x06, later bytes are acknowledged and delivered with `rx_is_gc` = 1.
- R5: With `gc_enable` = 0, address byte 0x00 is not acknowledged, and no strobe fires for that transfer.
- R6: Address byte 0x01 (broadcast with the read bit set) is never acknowledged, and `sda_oe` stays 0 for the whole transfer.
- R7: Command 0x06 produces one cycle in which `soft_reset`, `addr_latch` and `gc_cmd_valid` are all 1. Command 0x04 pulses `addr_latch` without `soft_reset`. After either command, later bytes in the same transfer are neither acknowledged nor delivered.
- R8: Command byte 0x00 is not acknowledged and gives no `gc_cmd_valid`.
- R9: An address byte {own_addr, 1} is acknowledged. The block then sends `tx_data`, MSB first, with one `tx_req` pulse at each byte load. It loads the next byte after a master ACK and stops driving after a master NACK.
- R10: A repeated START returns the block to address reception from any state, even in the middle of a byte.
- R11: `sda_oe` changes only while SCL is low. The ACK is driven from the falling edge after the 8th bit until the next falling edge.
- R12: `rx_valid`, `gc_cmd_valid` and `soft_reset` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Own slave address |
| gc_enable | input | 1 | 1 answers the broadcast address |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | Pulse: new byte on `rx_data` |
| rx_is_gc | output | 1 | The byte on `rx_data` came through a broadcast |
| gc_cmd | output | 8 | Last accepted broadcast command byte |
| gc_cmd_valid | output | 1 | Pulse: new command on `gc_cmd` |
| soft_reset | output | 1 | Pulse on command 0x06 |
| addr_latch | output | 1 | Pulse on command 0x04 or 0x06 |
| tx_data | input | 8 | Byte to send on a read |
| tx_req | output | 1 | Pulse: `tx_data` was loaded |

## Verification
Command 0x06 drives three outputs from one decision. The bench sends that command and compares the counts of `soft_reset`, `addr_latch` and `gc_cmd_valid` pulses with its reference tallies. A bound property also requires `soft_reset` never to appear without the other two in the same cycle. A second collision is a repeated START that lands while a data byte is still shifting. The bench aborts a write after three bits and restarts it, then checks that only the byte sent after the restart is delivered.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_RX, S_ACK, S_TX, S_MACK, S_SKIP
  } gcsState_t;

  typedef struct packed {
    logic clrCnt;
    logic loadTx;
    logic shiftTx;
  } dpCtl_t;

  localparam logic [7:0] CMD_RST_LATCH = 8'h06;
  localparam logic [7:0] CMD_LATCH     = 8'h04;
endpackage

// File: rtl/gcs_datapath.sv
module gcs_datapath
  import gcs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] txByte,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              sdaBit,
  output logic              byteDone,
  output logic [DATA_W-1:0] rxByte,
  output logic              txBit
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0] bitCnt;
  logic [DATA_W-1:0] txShift;

  // Lines idle high, so the synchronizers reset to 1 to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign byteDone = (bitCnt == CNT_W'(DATA_W));
  assign txBit    = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt  <= '0;
      rxByte  <= '0;
      txShift <= '1;
    end else begin
      if (ctl.clrCnt)
        bitCnt <= '0;
      else if (sclRise && !byteDone)
        bitCnt <= bitCnt + 1'b1;
      if (sclRise)
        rxByte <= {rxByte[DATA_W-2:0], sdaS};
      if (ctl.loadTx)
        txShift <= txByte;
      else if (ctl.shiftTx)
        txShift <= {txShift[DATA_W-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/gcs_control.sv
module gcs_control
  import gcs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaBit,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txBit,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  output dpCtl_t            ctl,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxIsGc,
  output logic [DATA_W-1:0] gcCmd,
  output logic              gcCmdValid,
  output logic              softReset,
  output logic              addrLatch,
  output logic              txReq
);
  gcsState_t state, nextAfterAck;
  logic gcMode, firstGc, masterAck;
  logic reloadTx;

  assign reloadTx = sclFall && !startDet && !stopDet &&
                    ((state == S_ACK && nextAfterAck == S_TX) ||
                     (state == S_MACK && masterAck));

  always_comb begin
    ctl.clrCnt  = startDet || (sclFall && (state == S_ACK || state == S_MACK));
    ctl.loadTx  = reloadTx;
    ctl.shiftTx = (state == S_TX) && sclFall && !byteDone;
  end

  // Multiple ACKs combine on the wire: drive low without checking the line.
  assign sdaOe = (state == S_ACK) || (state == S_TX && !txBit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      nextAfterAck <= S_IDLE;
      gcMode       <= 1'b0;
      firstGc      <= 1'b0;
      masterAck    <= 1'b0;
      rxData       <= '0;
      rxValid      <= 1'b0;
      rxIsGc       <= 1'b0;
      gcCmd        <= '0;
      gcCmdValid   <= 1'b0;
      softReset    <= 1'b0;
      addrLatch    <= 1'b0;
      txReq        <= 1'b0;
    end else begin
      rxValid    <= 1'b0;
      gcCmdValid <= 1'b0;
      softReset  <= 1'b0;
      addrLatch  <= 1'b0;
      txReq      <= reloadTx;
      if (startDet) begin
        state   <= S_ADDR;
        gcMode  <= 1'b0;
        firstGc <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE;
      end else begin
        unique case (state)
          S_ADDR: if (sclFall && byteDone) begin
            if (rxByte[DATA_W-1:1] == ownAddr) begin
              state        <= S_ACK;
              nextAfterAck <= rxByte[0] ? S_TX : S_RX;
            end else if (rxByte == '0 && gcEnable) begin
              state        <= S_ACK;
              nextAfterAck <= S_RX;
              gcMode       <= 1'b1;
              firstGc      <= 1'b1;
            end else begin
              state <= S_SKIP;
            end
          end
          S_RX: if (sclFall && byteDone) begin
            if (gcMode && firstGc) begin
              firstGc <= 1'b0;
              if (rxByte == '0) begin
                state <= S_SKIP;
              end else begin
                state        <= S_ACK;
                gcCmd        <= rxByte;
                gcCmdValid   <= 1'b1;
                softReset    <= (rxByte == CMD_RST_LATCH);
                addrLatch    <= (rxByte == CMD_RST_LATCH) || (rxByte == CMD_LATCH);
                nextAfterAck <= ((rxByte == CMD_RST_LATCH) || (rxByte == CMD_LATCH))
                                ? S_SKIP : S_RX;
              end
            end else begin
              state        <= S_ACK;
              nextAfterAck <= S_RX;
              rxData       <= rxByte;
              rxValid      <= 1'b1;
              rxIsGc       <= gcMode;
            end
          end
          S_ACK:  if (sclFall) state <= nextAfterAck;
          S_TX:   if (sclFall && byteDone) state <= S_MACK;
          S_MACK: begin
            if (sclRise) masterAck <= !sdaBit;
            if (sclFall) state <= masterAck ? S_TX : S_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bcast_i2c_slave.sv
module bcast_i2c_slave
  import gcs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_enable,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_is_gc,
  output logic [DATA_W-1:0] gc_cmd,
  output logic              gc_cmd_valid,
  output logic              soft_reset,
  output logic              addr_latch,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_req
);
  dpCtl_t ctl;
  logic sclRise, sclFall, startDet, stopDet, sdaBit, byteDone, txBit;
  logic [DATA_W-1:0] rxByte;

  gcs_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dp (
    .clk(clk), .rst_n(rst_n), .sclIn(scl_in), .sdaIn(sda_in), .ctl(ctl),
    .txByte(tx_data), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .byteDone(byteDone), .rxByte(rxByte), .txBit(txBit)
  );

  gcs_control #(.DATA_W(DATA_W)) ctrl (
    .clk(clk), .rst_n(rst_n), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaBit(sdaBit),
    .byteDone(byteDone), .rxByte(rxByte), .txBit(txBit),
    .ownAddr(own_addr), .gcEnable(gc_enable), .ctl(ctl), .sdaOe(sda_oe),
    .rxData(rx_data), .rxValid(rx_valid), .rxIsGc(rx_is_gc),
    .gcCmd(gc_cmd), .gcCmdValid(gc_cmd_valid), .softReset(soft_reset),
    .addrLatch(addr_latch), .txReq(tx_req)
  );
endmodule

// File: rtl/gcs_checker.sv
module gcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       rx_valid,
  input logic       gc_cmd_valid,
  input logic [7:0] gc_cmd,
  input logic       soft_reset,
  input logic       addr_latch
);
  a_r7_reset_with_latch: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> (addr_latch && gc_cmd_valid && gc_cmd == 8'h06));

  a_r7_latch_is_command: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch |-> (gc_cmd_valid && (gc_cmd == 8'h04 || gc_cmd == 8'h06)));

  a_r8_no_zero_command: assert property (@(posedge clk) disable iff (!rst_n)
    gc_cmd_valid |-> (gc_cmd != 8'h00));

  a_r11_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);

  a_r11_release_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_in);

  a_r12_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r12_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    gc_cmd_valid |=> !gc_cmd_valid);

  a_r12_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !soft_reset);
endmodule

bind bcast_i2c_slave gcs_checker chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .rx_valid(rx_valid), .gc_cmd_valid(gc_cmd_valid), .gc_cmd(gc_cmd),
  .soft_reset(soft_reset), .addr_latch(addr_latch)
);

// File: tb/bcast_i2c_slave_test.sv
module bcast_i2c_slave_test;
  localparam int Q = 6;               // system clocks per quarter SCL period
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sda_oe, gc_enable = 1'b1;
  logic [7:0] rx_data, gc_cmd, tx_data = 8'h00;
  logic rx_valid, rx_is_gc, gc_cmd_valid, soft_reset, addr_latch, tx_req;
  logic sdaLine;

  int checks = 0, fails = 0;
  int rxCnt = 0, cmdCnt = 0, srCnt = 0, latchCnt = 0, txCnt = 0, oeCnt = 0;
  int srAlone = 0;
  int expRx = 0, expCmd = 0, expSr = 0, expLatch = 0, expTx = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sda_oe;

  bcast_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(sclM), .sda_in(sdaLine), .sda_oe(sda_oe),
    .own_addr(OWN), .gc_enable(gc_enable), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_is_gc(rx_is_gc), .gc_cmd(gc_cmd), .gc_cmd_valid(gc_cmd_valid),
    .soft_reset(soft_reset), .addr_latch(addr_latch), .tx_data(tx_data), .tx_req(tx_req)
  );

  // Per-clock reference tallies of every strobe.
  always @(posedge clk) if (rst_n) begin
    if (rx_valid) rxCnt++;
    if (gc_cmd_valid) cmdCnt++;
    if (soft_reset) srCnt++;
    if (addr_latch) latchCnt++;
    if (tx_req) txCnt++;
    if (sda_oe) oeCnt++;
    if (soft_reset && !(addr_latch && gc_cmd_valid)) srAlone++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(1); sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1); sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1); sclM = 1'b1; waitQ(1); sdaM = 1'b1; waitQ(2);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaM = b; waitQ(1); sclM = 1'b1; waitQ(1);
    seen = sdaLine; waitQ(1); sclM = 1'b0; waitQ(1);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin clockBit(1'b1, s); v[i] = s; end
    clockBit(!mAck, s);
  endtask

  initial begin
    logic a;
    logic [7:0] rb;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 sda_oe", sda_oe, 0);
    check("R1 strobes", {rx_valid, gc_cmd_valid, soft_reset, addr_latch, tx_req}, 0);
    rst_n = 1'b1;
    waitQ(2);

    // R2: write to own address
    busStart(); writeByte({OWN, 1'b0}, a); check("R2 addr ack", a, 1);
    writeByte(8'hA5, a); check("R2 data ack", a, 1);
    writeByte(8'h3C, a); busStop(); expRx += 2;
    check("R2 rx count", rxCnt, expRx);
    check("R2 rx_data", rx_data, 8'h3C);
    check("R2 rx_is_gc", rx_is_gc, 0);

    // R3: foreign address
    busStart(); writeByte(8'h52, a); check("R3 nack", a, 0);
    writeByte(8'h11, a); busStop();
    check("R3 no rx", rxCnt, expRx);

    // R4: broadcast with user command
    busStart(); writeByte(8'h00, a); check("R4 gc ack", a, 1);
    writeByte(8'h55, a); check("R4 cmd ack", a, 1); expCmd++;
    writeByte(8'h9E, a); check("R4 data ack", a, 1); expRx++;
    busStop();
    check("R4 gc_cmd", gc_cmd, 8'h55);
    check("R4 cmd count", cmdCnt, expCmd);
    check("R4 rx count", rxCnt, expRx);
    check("R4 rx_data", rx_data, 8'h9E);
    check("R4 rx_is_gc", rx_is_gc, 1);

    // R5: broadcast disabled
    gc_enable = 1'b0;
    busStart(); writeByte(8'h00, a); check("R5 nack", a, 0);
    writeByte(8'h06, a); busStop();
    check("R5 no cmd", cmdCnt, expCmd);
    check("R5 no reset", srCnt, expSr);
    gc_enable = 1'b1;

    // R6: broadcast read is refused and never driven
    oeCnt = 0;
    busStart(); writeByte(8'h01, a); check("R6 nack", a, 0);
    readByte(1'b0, rb); busStop();
    check("R6 oe never", oeCnt, 0);

    // R7: 0x06 reset-and-latch, then trailing byte ignored
    busStart(); writeByte(8'h00, a);
    writeByte(8'h06, a); check("R7 cmd06 ack", a, 1);
    expCmd++; expSr++; expLatch++;
    writeByte(8'h77, a); check("R7 trailing nack", a, 0);
    busStop();
    check("R7 reset pulses", srCnt, expSr);
    check("R7 latch pulses", latchCnt, expLatch);
    check("R7 cmd pulses", cmdCnt, expCmd);
    check("R7 same cycle", srAlone, 0);
    check("R7 no rx", rxCnt, expRx);
    // R7: 0x04 latch only
    busStart(); writeByte(8'h00, a);
    writeByte(8'h04, a); check("R7 cmd04 ack", a, 1);
    busStop(); expCmd++; expLatch++;
    check("R7 04 latch", latchCnt, expLatch);
    check("R7 04 no reset", srCnt, expSr);

    // R8: zero command refused
    busStart(); writeByte(8'h00, a);
    writeByte(8'h00, a); check("R8 nack", a, 0);
    busStop();
    check("R8 no cmd", cmdCnt, expCmd);

    // R9: read from own address
    tx_data = 8'hC3;
    busStart(); writeByte({OWN, 1'b1}, a); check("R9 addr ack", a, 1);
    tx_data = 8'hC3;
    readByte(1'b1, rb); check("R9 byte0", rb, 8'hC3);
    readByte(1'b0, rb); check("R9 byte1", rb, 8'hC3);
    busStop(); expTx += 2;
    check("R9 tx_req", txCnt, expTx);
    check("R9 released", sda_oe, 0);

    // R10: repeated START in the middle of a data byte
    busStart(); writeByte({OWN, 1'b0}, a);
    for (int i = 0; i < 3; i++) clockBit(1'b0, a);
    busStart(); writeByte({OWN, 1'b0}, a); check("R10 addr ack", a, 1);
    writeByte(8'h6B, a); busStop(); expRx++;
    check("R10 rx count", rxCnt, expRx);
    check("R10 rx_data", rx_data, 8'h6B);

    // R11/R12 are also held by bound properties; idle line check here
    check("R11 idle release", sda_oe, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule